// File: doc/BRIEF.md
# UART FIFO Pacing and Trigger Controller

This block holds the transmit and receive character FIFOs of a UART, each 16 entries deep, and the logic that paces a DMA engine around them. A single control-register write sets the FIFO enable, the DMA pacing style and a 2-bit receive trigger level. From those settings and the live occupancy it drives two active-low pacing pins, one for transmit and one for receive. It also raises a receive data-available interrupt request once the receive count reaches the selected trigger level. The serial shifters, baud generation and the receive-timeout counter are outside the block; the timeout counter delivers a one-cycle pulse on `rx_timeout`.

Characters enter and leave each FIFO on valid/ready streams. On the input side a character moves on a clock edge where `*_in_valid` and `*_in_ready` are both high. `*_in_ready` is low exactly when the FIFO is at capacity, so a character offered while full is not taken and counts as dropped. On the output side a character is removed on an edge where `*_out_valid` and `*_out_ready` are both high. `*_out_ready` with the FIFO empty has no effect. While the FIFO is empty, `*_out_data` keeps showing the most recently accepted character. Neither stream needs ready to wait for valid, or valid to wait for ready.

All outputs derive from registered state. The effect of a strobe sampled on one clock edge is therefore visible right after that edge.

Top module: `uart_fifo_pacer`

## Requirements
- R1: Pacing style 1 is active only when control bit 0 (FIFO enable) and control bit 3 (pacing select) are both 1. Otherwise `txrdy_n` is 0 while the transmit FIFO is empty and 1 otherwise, and `rxrdy_n` is 0 while the receive FIFO holds at least one character and 1 when it is empty.
- R2: Control bits 7:6 pick the receive trigger level: 00 means 1 character, 01 means 4, 10 means 8 and 11 means 14. After reset the field is 00. While bit 0 is 0 the effective trigger level is 1.
- R3: FIFO capacity is 16 when bit 0 is 1 and 1 when bit 0 is 0. `*_in_ready` is 0 exactly when the count equals the capacity, and a character offered then is not stored. The receive FIFO keeps accepting characters past the trigger level until it is full. `*_full` and `*_empty` follow the count.
- R4: A pop happens only when `*_out_valid` and `*_out_ready` are both 1, and `*_out_valid` is 1 whenever the count is non-zero. The data output shows the oldest stored character when the FIFO is non-empty, and the most recently accepted character when it is empty (0 if none since reset). A pop request while empty leaves the count and the data unchanged.
- R5: In pacing style 1, `txrdy_n` is 1 only when the transmit FIFO holds 16 characters, and 0 whenever at least one location is free.
- R6: In pacing style 1, `rxrdy_n` goes to 0 after a push leaves the receive count at or above the trigger level, or after an `rx_timeout` pulse while the FIFO still holds data. Once it is 0, it returns to 1 only when the receive FIFO becomes empty.
- R7: `rx_irq` is re-evaluated only on edges where the receive count changes. It then becomes 1 if the new count is at or above the effective trigger level and 0 otherwise, so a change of trigger level takes effect at the next count change.
- R8: Control bits 1, 2, 4 and 5 are ignored. A write that differs only in those bits has no effect on any output.
- R9: A control write that changes bit 0 empties both FIFOs on the same edge and clears the receive-ready latch and `rx_irq`.
- R10: After reset the control fields are 0, both counts are 0, both FIFOs report empty, `txrdy_n` is 0, `rxrdy_n` is 1 and `rx_irq` is 0.
- R11: A push, pop or control write sampled on one rising edge is reflected in the counts, flags and pins right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| tx_in_valid | input | 1 | Transmit character offered |
| tx_in_data | input | 8 | Transmit character |
| tx_in_ready | output | 1 | Transmit FIFO can take a character |
| tx_out_valid | output | 1 | Transmit FIFO holds a character |
| tx_out_data | output | 8 | Oldest transmit character (last accepted when empty) |
| tx_out_ready | input | 1 | Shifter takes the transmit character |
| rx_in_valid | input | 1 | Received character offered |
| rx_in_data | input | 8 | Received character |
| rx_in_ready | output | 1 | Receive FIFO can take a character |
| rx_out_valid | output | 1 | Receive FIFO holds a character |
| rx_out_data | output | 8 | Oldest received character (last accepted when empty) |
| rx_out_ready | input | 1 | Reader takes the received character |
| rx_timeout | input | 1 | One-cycle receive timeout pulse |
| txrdy_n | output | 1 | Transmit pacing pin, active low |
| rxrdy_n | output | 1 | Receive pacing pin, active low |
| rx_irq | output | 1 | Receive data-available interrupt request |
| tx_count | output | 5 | Transmit FIFO occupancy |
| rx_count | output | 5 | Receive FIFO occupancy |
| tx_full | output | 1 | Transmit FIFO at capacity |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_full | output | 1 | Receive FIFO at capacity |
| rx_empty | output | 1 | Receive FIFO empty |

## Verification
The bench builds the block with its default parameters: a depth of 16 and 8-bit characters. At that depth every one of the four trigger levels lies below capacity, so each level can be crossed upward and then drained. The full condition that drives transmit pacing in style 1 can be reached in a few cycles. Toggling the enable bit also switches the capacity between 16 and 1, which covers the single-character holding behaviour and the flush on the same run.

// File: rtl/fifotrig_pkg.sv
package fifotrig_pkg;

  typedef struct packed {
    logic [1:0] trig_sel;
    logic       pace_sel;
    logic       en;
  } fcfg_t;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/fifotrig_ctrl.sv
module fifotrig_ctrl
  import fifotrig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output fcfg_t      cfg,
  output logic       flush
);

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[5:4], cfg_wdata[2:1]};

  assign flush = cfg_wr && (cfg_wdata[0] != cfg.en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_wr) begin
      cfg.trig_sel <= cfg_wdata[7:6];
      cfg.pace_sel <= cfg_wdata[3];
      cfg.en       <= cfg_wdata[0];
    end
  end

  // R2: trigger field follows the written bits 7:6
  p_trig_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg.trig_sel == $past(cfg_wdata[7:6])));

  // R8: a write leaves the enable bit equal to written bit 0 regardless of ignored bits
  p_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !flush) |=> $stable(cfg.en));

endmodule

// File: rtl/fifotrig_fifo.sv
module fifotrig_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign full      = (count >= cap);
  assign empty     = (count == '0);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign push_ok   = in_valid && in_ready;
  assign pop_ok    = out_ready && out_valid;

  // Empty: show the slot written last (most recently accepted character)
  assign out_data  = empty ? mem[ptr_dec(wr_ptr)] : mem[rd_ptr];

  always_comb begin
    if (flush) count_nxt = '0;
    else       count_nxt = count + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_ok) begin
        mem[wr_ptr] <= in_data;
        wr_ptr      <= ptr_inc(wr_ptr);
      end
      if (flush)       rd_ptr <= push_ok ? ptr_inc(wr_ptr) : wr_ptr;
      else if (pop_ok) rd_ptr <= ptr_inc(rd_ptr);
      count <= count_nxt;
    end
  end

  // R3: occupancy never exceeds the storage depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R3: at capacity with no pop or flush, the count holds
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_ok && !flush) |=> (count == $past(count)));

  // R4: empty with nothing offered keeps count at zero and data stable
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !in_valid) |=> (empty && $stable(out_data)));

endmodule

// File: rtl/fifotrig_pace.sv
module fifotrig_pace
  import fifotrig_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fcfg_t         cfg,
  input  logic          flush,
  input  logic          cfg_wr,
  input  logic          rx_push_ok,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_count_nxt,
  input  logic [CW-1:0] tx_count,
  input  logic          rx_timeout,
  output logic          txrdy_n,
  output logic          rxrdy_n,
  output logic          rx_irq
);

  logic          mode1;
  logic [CW-1:0] eff_trig;
  logic          rx_latch, rx_latch_nxt, irq_nxt;

  assign mode1    = cfg.en && cfg.pace_sel;
  assign eff_trig = cfg.en ? CW'(trig_level(cfg.trig_sel)) : CW'(1);

  always_comb begin
    rx_latch_nxt = rx_latch;
    if (flush || rx_count_nxt == '0)
      rx_latch_nxt = 1'b0;
    else if ((rx_push_ok && rx_count_nxt >= eff_trig) || rx_timeout)
      rx_latch_nxt = 1'b1;
  end

  always_comb begin
    irq_nxt = rx_irq;
    if (flush)                         irq_nxt = 1'b0;
    else if (rx_count_nxt != rx_count) irq_nxt = (rx_count_nxt >= eff_trig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_latch <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      rx_latch <= rx_latch_nxt;
      rx_irq   <= irq_nxt;
    end
  end

  assign txrdy_n = mode1 ? (tx_count == CW'(DEPTH)) : (tx_count != '0);
  assign rxrdy_n = mode1 ? !rx_latch : (rx_count == '0);

  // R6: once active in style 1, receive-ready holds while data remains
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && !rxrdy_n && !cfg_wr && rx_count_nxt != '0) |=> !rxrdy_n);

  // R7: the interrupt moves only together with the receive count
  p_irq_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_irq) |-> (rx_count != $past(rx_count)));

  // R7: a pending interrupt implies stored data
  p_irq_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_count != '0));

endmodule

// File: rtl/uart_fifo_pacer.sv
module uart_fifo_pacer
  import fifotrig_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_wdata,
  input  logic          tx_in_valid,
  input  logic [W-1:0]  tx_in_data,
  output logic          tx_in_ready,
  output logic          tx_out_valid,
  output logic [W-1:0]  tx_out_data,
  input  logic          tx_out_ready,
  input  logic          rx_in_valid,
  input  logic [W-1:0]  rx_in_data,
  output logic          rx_in_ready,
  output logic          rx_out_valid,
  output logic [W-1:0]  rx_out_data,
  input  logic          rx_out_ready,
  input  logic          rx_timeout,
  output logic          txrdy_n,
  output logic          rxrdy_n,
  output logic          rx_irq,
  output logic [CW-1:0] tx_count,
  output logic [CW-1:0] rx_count,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          rx_empty
);

  fcfg_t         cfg;
  logic          flush;
  logic [CW-1:0] cap;
  logic [CW-1:0] tx_count_nxt, rx_count_nxt;
  logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic          unused_sig;

  assign cap        = cfg.en ? CW'(DEPTH) : CW'(1);
  assign unused_sig = ^{tx_count_nxt, tx_push_ok, tx_pop_ok, rx_pop_ok};

  fifotrig_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg       (cfg),
    .flush     (flush)
  );

  fifotrig_fifo #(.DEPTH(DEPTH), .W(W)) u_txf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cap       (cap),
    .in_valid  (tx_in_valid),
    .in_data   (tx_in_data),
    .in_ready  (tx_in_ready),
    .out_valid (tx_out_valid),
    .out_data  (tx_out_data),
    .out_ready (tx_out_ready),
    .count     (tx_count),
    .count_nxt (tx_count_nxt),
    .full      (tx_full),
    .empty     (tx_empty),
    .push_ok   (tx_push_ok),
    .pop_ok    (tx_pop_ok)
  );

  fifotrig_fifo #(.DEPTH(DEPTH), .W(W)) u_rxf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cap       (cap),
    .in_valid  (rx_in_valid),
    .in_data   (rx_in_data),
    .in_ready  (rx_in_ready),
    .out_valid (rx_out_valid),
    .out_data  (rx_out_data),
    .out_ready (rx_out_ready),
    .count     (rx_count),
    .count_nxt (rx_count_nxt),
    .full      (rx_full),
    .empty     (rx_empty),
    .push_ok   (rx_push_ok),
    .pop_ok    (rx_pop_ok)
  );

  fifotrig_pace #(.DEPTH(DEPTH)) u_pace (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg          (cfg),
    .flush        (flush),
    .cfg_wr       (cfg_wr),
    .rx_push_ok   (rx_push_ok),
    .rx_count     (rx_count),
    .rx_count_nxt (rx_count_nxt),
    .tx_count     (tx_count),
    .rx_timeout   (rx_timeout),
    .txrdy_n      (txrdy_n),
    .rxrdy_n      (rxrdy_n),
    .rx_irq       (rx_irq)
  );

  // R5: in style 1 an active transmit-ready pin means a free slot exists
  p_txrdy_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && cfg.pace_sel && !txrdy_n) |-> tx_in_ready);

  // R3: with the FIFOs disabled, at most one character is held
  p_cap_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> (rx_count <= CW'(1) && tx_count <= CW'(1)));

  // R1: outside style 1 an active receive-ready pin means data is present
  p_rx_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cfg.en && cfg.pace_sel) && !rxrdy_n) |-> rx_out_valid);

  // R9: an enable change empties both FIFOs
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_empty && rx_empty && !rx_irq));

endmodule

// File: tb/sim_uart_fifo_pacer.sv
`timescale 1ns/1ps
module sim_uart_fifo_pacer;

  localparam int DEPTH = 16;
  localparam int W     = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr;
  logic [7:0]    cfg_wdata;
  logic          tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready;
  logic [W-1:0]  tx_in_data, tx_out_data;
  logic          rx_in_valid, rx_in_ready, rx_out_valid, rx_out_ready;
  logic [W-1:0]  rx_in_data, rx_out_data;
  logic          rx_timeout, txrdy_n, rxrdy_n, rx_irq;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_full, tx_empty, rx_full, rx_empty;

  always #4 clk = ~clk;

  uart_fifo_pacer #(.DEPTH(DEPTH), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_ready(rx_in_ready),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_ready(rx_out_ready),
    .rx_timeout(rx_timeout), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .rx_irq(rx_irq),
    .tx_count(tx_count), .rx_count(rx_count), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit chk_on = 0;
  bit done   = 0;

  // Behavioural reference state
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] last_tx, last_rx;
  bit         m_en, m_pace, m_latch, m_irq;
  logic [1:0] m_sel;

  function automatic int lvl(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : (s == 2'b10) ? 8 : 14;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    int cap, trig, rb, ra;
    bit tpush, tpop, rpush, rpop, fl;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      last_tx = 0; last_rx = 0;
      m_en = 0; m_pace = 0; m_sel = 0; m_latch = 0; m_irq = 0;
    end else begin
      cap   = m_en ? DEPTH : 1;
      trig  = m_en ? lvl(m_sel) : 1;
      fl    = cfg_wr && (cfg_wdata[0] != m_en);
      tpush = tx_in_valid && (txq.size() < cap);
      tpop  = tx_out_ready && (txq.size() > 0);
      rpush = rx_in_valid && (rxq.size() < cap);
      rpop  = rx_out_ready && (rxq.size() > 0);
      rb    = rxq.size();
      if (tpop) void'(txq.pop_front());
      if (tpush) begin txq.push_back(tx_in_data); last_tx = tx_in_data; end
      if (rpop) void'(rxq.pop_front());
      if (rpush) begin rxq.push_back(rx_in_data); last_rx = rx_in_data; end
      if (fl) begin txq.delete(); rxq.delete(); end
      ra = rxq.size();
      if (fl || ra == 0) m_latch = 0;
      else if ((rpush && ra >= trig) || rx_timeout) m_latch = 1;
      if (fl) m_irq = 0;
      else if (ra != rb) m_irq = (ra >= trig);
      if (cfg_wr) begin
        m_en = cfg_wdata[0]; m_pace = cfg_wdata[3]; m_sel = cfg_wdata[7:6];
      end
    end
  end

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (chk_on && !done) begin : cmp
      int cap;
      bit m1;
      cap = m_en ? DEPTH : 1;
      m1  = m_en && m_pace;
      chk("R3", "tx_count", tx_count, txq.size());
      chk("R3", "rx_count", rx_count, rxq.size());
      chk("R3", "tx_full", tx_full, txq.size() >= cap);
      chk("R3", "rx_full", rx_full, rxq.size() >= cap);
      chk("R3", "tx_empty", tx_empty, txq.size() == 0);
      chk("R3", "rx_empty", rx_empty, rxq.size() == 0);
      chk("R3", "tx_in_ready", tx_in_ready, txq.size() < cap);
      chk("R3", "rx_in_ready", rx_in_ready, rxq.size() < cap);
      chk("R4", "tx_out_valid", tx_out_valid, txq.size() > 0);
      chk("R4", "rx_out_valid", rx_out_valid, rxq.size() > 0);
      chk("R4", "tx_out_data", tx_out_data, (txq.size() > 0) ? txq[0] : last_tx);
      chk("R4", "rx_out_data", rx_out_data, (rxq.size() > 0) ? rxq[0] : last_rx);
      if (m1) begin
        chk("R5", "txrdy_n", txrdy_n, txq.size() == DEPTH);
        chk("R6", "rxrdy_n", rxrdy_n, !m_latch);
      end else begin
        chk("R1", "txrdy_n", txrdy_n, txq.size() != 0);
        chk("R1", "rxrdy_n", rxrdy_n, rxq.size() == 0);
      end
      chk("R7", "rx_irq", rx_irq, m_irq);
    end
  end

  logic [7:0] seq = 8'h10;

  task automatic step(input bit tv, input bit tr, input bit rv, input bit rr,
                      input bit to, input bit wr, input logic [7:0] wd);
    tx_in_valid = tv; tx_out_ready = tr; rx_in_valid = rv; rx_out_ready = rr;
    rx_timeout = to; cfg_wr = wr; cfg_wdata = wd;
    seq = seq + 8'd7;
    tx_in_data = seq; rx_in_data = ~seq;
    @(negedge clk); #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) begin
      if (tx_count == 0 && rx_count == 0) break;
      step(0, 1, 0, 1, 0, 0, 8'h00);
    end
    idle();
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] first_rx;
    rst_n = 0;
    step(0, 0, 0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 0, 0, 8'h00);
    // R10: reset state
    chk("R10", "tx_count", tx_count, 0);
    chk("R10", "rx_count", rx_count, 0);
    chk("R10", "tx_empty", tx_empty, 1);
    chk("R10", "rx_empty", rx_empty, 1);
    chk("R10", "txrdy_n", txrdy_n, 0);
    chk("R10", "rxrdy_n", rxrdy_n, 1);
    chk("R10", "rx_irq", rx_irq, 0);
    rst_n = 1;
    chk_on = 1;
    idle();

    // FIFOs disabled: single-character holding
    step(0, 0, 1, 0, 0, 0, 8'h00);
    first_rx = rx_in_data;
    chk("R11", "rx_count after push", rx_count, 1);
    chk("R1", "rxrdy_n holding", rxrdy_n, 0);
    chk("R7", "irq at level 1", rx_irq, 1);
    step(0, 0, 1, 0, 0, 0, 8'h00);
    chk("R3", "second push dropped", rx_count, 1);
    step(0, 0, 0, 1, 0, 0, 8'h00);
    chk("R4", "rx data after drain", rx_out_data, first_rx);
    step(0, 0, 0, 1, 0, 0, 8'h00);
    chk("R4", "pop on empty count", rx_count, 0);
    chk("R4", "pop on empty data", rx_out_data, first_rx);

    // FIFO mode, style 0: fill transmit
    step(0, 0, 0, 0, 0, 1, 8'h01);
    for (int i = 0; i < 17; i++) step(1, 0, 0, 0, 0, 0, 8'h00);
    chk("R3", "tx full at 16", tx_count, 16);
    chk("R1", "txrdy_n style 0", txrdy_n, 1);
    // style 1 without flush
    step(0, 0, 0, 0, 0, 1, 8'h09);
    chk("R5", "txrdy_n full", txrdy_n, 1);
    chk("R9", "no flush same enable", tx_count, 16);
    step(0, 1, 0, 0, 0, 0, 8'h00);
    chk("R5", "txrdy_n one free", txrdy_n, 0);
    drain();

    // Each trigger level in style 1
    for (int s = 0; s < 4; s++) begin
      step(0, 0, 0, 0, 0, 1, {s[1:0], 6'b001001});
      for (int k = 1; k < lvl(s[1:0]); k++) step(0, 0, 1, 0, 0, 0, 8'h00);
      chk("R6", "rxrdy_n below level", rxrdy_n, 1);
      chk("R2", "irq below level", rx_irq, 0);
      step(0, 0, 1, 0, 0, 0, 8'h00);
      chk("R6", "rxrdy_n at level", rxrdy_n, 0);
      chk("R2", "irq at level", rx_irq, 1);
      for (int k = 1; k < lvl(s[1:0]); k++) step(0, 0, 0, 1, 0, 0, 8'h00);
      chk("R6", "rxrdy_n held with one left", rxrdy_n, 0);
      step(0, 0, 0, 1, 0, 0, 8'h00);
      chk("R6", "rxrdy_n released at empty", rxrdy_n, 1);
    end
    // beyond the trigger until full
    for (int k = 0; k < 18; k++) step(0, 0, 1, 0, 0, 0, 8'h00);
    chk("R3", "rx fills past trigger", rx_count, 16);
    drain();

    // Timeout with data below level 14
    step(0, 0, 1, 0, 0, 0, 8'h00);
    chk("R6", "rxrdy_n before timeout", rxrdy_n, 1);
    step(0, 0, 0, 0, 1, 0, 8'h00);
    chk("R6", "rxrdy_n after timeout", rxrdy_n, 0);
    chk("R7", "no irq from timeout", rx_irq, 0);

    // Ignored bits: keep en, pace and sel=11
    step(0, 0, 0, 0, 0, 1, 8'hFF);
    chk("R8", "count kept", rx_count, 1);
    chk("R8", "rxrdy_n kept", rxrdy_n, 0);
    chk("R8", "irq kept", rx_irq, 0);

    // Flush by clearing enable
    step(1, 0, 1, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 0, 1, 8'h00);
    chk("R9", "tx flushed", tx_count, 0);
    chk("R9", "rx flushed", rx_count, 0);
    chk("R9", "rxrdy_n cleared", rxrdy_n, 1);

    // Mixed traffic with occasional control writes
    for (int c = 0; c < 4000; c++) begin
      bit wr;
      wr = ($urandom_range(0, 59) == 0);
      step($urandom_range(0, 99) < 55, $urandom_range(0, 99) < 45,
           $urandom_range(0, 99) < 50, $urandom_range(0, 99) < 40,
           $urandom_range(0, 29) == 0, wr,
           {$urandom_range(0, 3), 2'b00, $urandom_range(0, 1) == 1 ? 1'b1 : 1'b0,
            2'b00, $urandom_range(0, 4) != 0 ? 1'b1 : 1'b0});
    end
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule